// File: doc/BRIEF.md
# Snooping MEI Write-Back Data Cache Controller

This block is a four-way set-associative data cache that sits between a CPU load/store port and a burst memory bus. It holds 16 KB as 128 sets of four 32-byte lines. Each line has an address tag and a two-bit coherency state: Invalid, Exclusive or Modified. Word stores that hit change the line in place and leave memory stale until the line leaves the cache. A miss picks a victim way by least-recently-used age. If that victim is Modified, its contents are written out as a four-beat burst. The missing line is then fetched as a four-beat burst of 64-bit beats, starting with the beat that holds the requested word.

A snoop port takes line addresses seen on the external bus. A snoop that hits a Modified line holds the bus requester off with a retry signal, pushes the line to memory and then invalidates it. A snoop that hits an Exclusive line invalidates it at once. A snoop that misses changes nothing. The controller handles one operation at a time. CPU requests and snoops are level requests, held until the matching completion pulse. When both are pending, the snoop is taken first.

Top module: `snoop_mei_dcache`

## Requirements
- R1: Synchronous active-low reset sets every line to Invalid, and leaves cpu_ready, snoop_ack, snoop_retry and mem_req low.
- R2: A load or store that hits completes with a one-cycle cpu_ready pulse on the second rising edge after the request is first sampled, and starts no memory traffic. Word k of a line is bits [32k+31:32k] of the line.
- R3: A load miss to a clean or empty way fetches the line with exactly four read beats. The burst address carries the requested word's beat index in bits [4:3], and beats then wrap through the line. Beat b holds words 2b (bits 31:0) and 2b+1 (bits 63:32). The requested word is returned with cpu_ready seven edges after the request is sampled.
- R4: A store hit replaces only the addressed word, writes nothing to memory and leaves the line Modified.
- R5: A store miss fills the line, then merges the store, and completes on the seventh edge. The line is then Modified.
- R6: The victim is an Invalid way when one exists, and otherwise the least-recently-used way of the set. Hits and fills both count as a use.
- R7: A Modified victim is first written out as four beats from beat 0 at the victim's own line address, and then the new line is fetched. A load that causes this completes on the twelfth edge.
- R8: A snoop hitting an Exclusive line invalidates it with no retry and no memory traffic, and snoop_ack pulses two edges after the snoop is sampled.
- R9: A snoop hitting a Modified line raises snoop_retry, writes the line out in four beats and invalidates it. snoop_retry falls in the same cycle that snoop_ack pulses, six edges after the snoop is sampled.
- R10: A snoop that misses changes no line and is acknowledged two edges after it is sampled.
- R11: When a snoop and a CPU request are pending together while idle, the snoop is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 30 | Word address (byte address bits 31:2) |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Burst in progress |
| mem_we | output | 1 | 1 = cast-out write, 0 = fill read |
| mem_addr | output | 32 | Burst start byte address |
| mem_wdata | output | 64 | Write beat data |
| mem_rdata | input | 64 | Read beat data |
| mem_ack | input | 1 | One beat transferred this cycle |
| snoop_valid | input | 1 | Snoop request, held until snoop_ack |
| snoop_addr | input | 27 | Snooped line address (byte address bits 31:5) |
| snoop_retry | output | 1 | Requester must retry; modified line being pushed |
| snoop_ack | output | 1 | One-cycle snoop completion pulse |

## Verification
Every result has a fixed number of edges after its request is first sampled, as long as memory acknowledges one beat per cycle. The counts are two for a hit, seven for a clean miss, twelve for a miss with a dirty victim, two for snoops that miss or hit Exclusive lines, and six for a snoop that pushes a Modified line. In the priority case, the CPU hit completes four edges after the joint request. The bench drives inputs and samples outputs on falling edges. It counts those edges from the request to the completion pulse and compares the count with these numbers. It also counts bus beats and records each burst's start address, which shows the fill order, the cast-out order and the absence of traffic.

// File: rtl/dc_pkg.sv
// Shared types for the snooping write-back data cache.
// Assumes two state bits per line; encoding 2'b10 is never produced.
package dc_pkg;
    typedef enum logic [1:0] {
        LS_INV  = 2'b00,
        LS_EXCL = 2'b01,
        LS_MOD  = 2'b11
    } line_st_t;

    typedef enum logic [2:0] {
        C_IDLE,
        C_LOOK,
        C_SNOOP,
        C_CAST,
        C_FILL
    } ctl_t;
endpackage

// File: rtl/dc_lru.sv
// Per-set pairwise age matrix for least-recently-used replacement.
// Bit for pair (i,j), i<j, is 1 when way i was used more recently than way j.
// Assumes touch and victim lookup address the same set in a given cycle.
module dc_lru #(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  set_idx,
    input  logic [WAYS-1:0]          valid_row,
    input  logic                     touch_en,
    input  logic [$clog2(WAYS)-1:0]  touch_way,
    output logic [$clog2(WAYS)-1:0]  victim
);
    localparam int PAIRS = WAYS * (WAYS - 1) / 2;
    localparam int WAY_W = $clog2(WAYS);

    logic [PAIRS-1:0] age_q [SETS];
    logic [PAIRS-1:0] row;
    logic [PAIRS-1:0] touched;

    function automatic int pidx(input int i, input int j);
        return i * (2 * WAYS - i - 1) / 2 + (j - i - 1);
    endfunction

    // Victim choice: lowest Invalid way, else the way newer than no other.
    always_comb begin
        logic found;
        logic oldest;
        row    = age_q[set_idx];
        found  = 1'b0;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_row[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            oldest = 1'b1;
            for (int j = 0; j < WAYS; j++) begin
                if (j != w) begin
                    if (w < j ? row[pidx(w, j)] : !row[pidx(j, w)]) oldest = 1'b0;
                end
            end
            if (!found && oldest) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
    end

    // Make the touched way newer than every other way of the set.
    always_comb begin
        touched = row;
        for (int j = 0; j < WAYS; j++) begin
            if (j != int'(touch_way)) begin
                if (int'(touch_way) < j) touched[pidx(int'(touch_way), j)] = 1'b1;
                else                     touched[pidx(j, int'(touch_way))] = 1'b0;
            end
        end
    end

    // Age storage: cleared on reset, written on each use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) age_q[s] <= '0;
        end else if (touch_en) begin
            age_q[set_idx] <= touched;
        end
    end
endmodule

// File: rtl/dc_tag_match.sv
// Parallel tag compare across the ways of one set.
// Assumes at most one valid way holds a given tag.
module dc_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [WAYS-1:0][1:0]       row_st,
    input  logic [TAG_W-1:0]           tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic [$clog2(WAYS)-1:0]    hit_way
);
    import dc_pkg::*;

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = (row_st[w] != LS_INV) && (row_tag[w] == tag);
    end

    // Encode the matching way.
    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = $clog2(WAYS)'(w);
        end
    end
endmodule

// File: rtl/snoop_mei_dcache.sv
// Four-way write-back data cache with MEI coherency and bus snooping.
// Serves one CPU access or snoop at a time. Misses fill by 4-beat wrapped bursts.
// Dirty victims and snooped dirty lines are written out first.
// Assumes memory holds mem_ack low for at least one cycle between bursts.
module snoop_mei_dcache #(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_W     = 64,
    parameter int WORD_W     = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cpu_req,
    input  logic                                   cpu_we,
    input  logic [ADDR_W-1:$clog2(WORD_W/8)]       cpu_addr,
    input  logic [WORD_W-1:0]                      cpu_wdata,
    output logic                                   cpu_ready,
    output logic [WORD_W-1:0]                      cpu_rdata,
    output logic                                   mem_req,
    output logic                                   mem_we,
    output logic [ADDR_W-1:0]                      mem_addr,
    output logic [BEAT_W-1:0]                      mem_wdata,
    input  logic [BEAT_W-1:0]                      mem_rdata,
    input  logic                                   mem_ack,
    input  logic                                   snoop_valid,
    input  logic [ADDR_W-1:$clog2(LINE_BYTES)]     snoop_addr,
    output logic                                   snoop_retry,
    output logic                                   snoop_ack
);
    import dc_pkg::*;

    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(SETS);
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int BEATS      = LINE_W / BEAT_W;
    localparam int BSEL_W     = $clog2(BEATS);
    localparam int WSEL_W     = $clog2(LINE_W / WORD_W);
    localparam int WORD_OFF   = $clog2(WORD_W / 8);
    localparam int BEAT_OFF   = $clog2(BEAT_W / 8);
    localparam int WAY_W      = $clog2(WAYS);

    ctl_t                       ctl_q;
    logic [ADDR_W-1:WORD_OFF]   addr_q;
    logic                       we_q;
    logic                       snp_q;
    logic [WORD_W-1:0]          wdata_q;
    logic [WAY_W-1:0]           way_q;
    logic [BSEL_W-1:0]          bcnt_q;
    logic [LINE_W-1:0]          fill_q;

    logic [TAG_W-1:0]           tag_q  [SETS][WAYS];
    logic [1:0]                 st_q   [SETS][WAYS];
    logic [LINE_W-1:0]          data_q [SETS][WAYS];

    logic [IDX_W-1:0]           idx;
    logic [TAG_W-1:0]           tag;
    logic [WSEL_W-1:0]          wsel;
    logic [BSEL_W-1:0]          crit;
    logic [BSEL_W-1:0]          beat_pos;
    logic [WAYS-1:0][TAG_W-1:0] row_tag;
    logic [WAYS-1:0][1:0]       row_st;
    logic [WAYS-1:0]            valid_row;
    logic [WAYS-1:0]            hit_vec;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           victim;
    logic                       last_beat;
    logic                       fill_done;
    logic                       store_hit;
    logic                       touch_en;
    logic [LINE_W-1:0]          fill_next;

    // Field split of the held address and the current set row.
    always_comb begin
        idx  = addr_q[OFF_W +: IDX_W];
        tag  = addr_q[ADDR_W-1 -: TAG_W];
        wsel = addr_q[WORD_OFF +: WSEL_W];
        crit = addr_q[BEAT_OFF +: BSEL_W];
        for (int w = 0; w < WAYS; w++) begin
            row_tag[w]   = tag_q[idx][w];
            row_st[w]    = st_q[idx][w];
            valid_row[w] = st_q[idx][w] != LS_INV;
        end
    end

    dc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .row_tag (row_tag),
        .row_st  (row_st),
        .tag     (tag),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_way (hit_way)
    );

    dc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx   (idx),
        .valid_row (valid_row),
        .touch_en  (touch_en),
        .touch_way (ctl_q == C_FILL ? way_q : hit_way),
        .victim    (victim)
    );

    // Burst beat position, bus outputs and array write strobes.
    always_comb begin
        beat_pos  = (ctl_q == C_FILL ? crit : '0) + bcnt_q;
        last_beat = mem_ack && (bcnt_q == BSEL_W'(BEATS - 1));
        fill_done = (ctl_q == C_FILL) && last_beat;
        store_hit = (ctl_q == C_LOOK) && hit && we_q;
        touch_en  = fill_done || ((ctl_q == C_LOOK) && hit);
        mem_req   = (ctl_q == C_FILL) || (ctl_q == C_CAST);
        mem_we    = (ctl_q == C_CAST);
        mem_addr  = (ctl_q == C_CAST)
                  ? {tag_q[idx][way_q], idx, {OFF_W{1'b0}}}
                  : {tag, idx, crit, {BEAT_OFF{1'b0}}};
        mem_wdata = data_q[idx][way_q][beat_pos*BEAT_W +: BEAT_W];
        fill_next = fill_q;
        fill_next[beat_pos*BEAT_W +: BEAT_W] = mem_rdata;
    end

    // Line data and tag storage: written on fill completion and store hits.
    always_ff @(posedge clk) begin
        if (fill_done) begin
            data_q[idx][way_q] <= fill_next;
            tag_q[idx][way_q]  <= tag;
        end else if (store_hit) begin
            data_q[idx][hit_way][wsel*WORD_W +: WORD_W] <= wdata_q;
        end
    end

    // Sequencer: lookup, snoop, cast-out and fill, plus line state updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= C_IDLE;
            cpu_ready   <= 1'b0;
            cpu_rdata   <= '0;
            snoop_ack   <= 1'b0;
            snoop_retry <= 1'b0;
            bcnt_q      <= '0;
            way_q       <= '0;
            snp_q       <= 1'b0;
            we_q        <= 1'b0;
            wdata_q     <= '0;
            addr_q      <= '0;
            fill_q      <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) st_q[s][w] <= LS_INV;
        end else begin
            cpu_ready <= 1'b0;
            snoop_ack <= 1'b0;
            case (ctl_q)
                C_IDLE: begin
                    if (snoop_valid) begin
                        addr_q <= {snoop_addr, {(OFF_W-WORD_OFF){1'b0}}};
                        ctl_q  <= C_SNOOP;
                    end else if (cpu_req) begin
                        addr_q  <= cpu_addr;
                        we_q    <= cpu_we;
                        wdata_q <= cpu_wdata;
                        ctl_q   <= C_LOOK;
                    end
                end
                C_LOOK: begin
                    bcnt_q <= '0;
                    if (hit) begin
                        cpu_ready <= 1'b1;
                        cpu_rdata <= data_q[idx][hit_way][wsel*WORD_W +: WORD_W];
                        if (we_q) st_q[idx][hit_way] <= LS_MOD;
                        ctl_q <= C_IDLE;
                    end else begin
                        way_q <= victim;
                        snp_q <= 1'b0;
                        ctl_q <= (st_q[idx][victim] == LS_MOD) ? C_CAST : C_FILL;
                    end
                end
                C_SNOOP: begin
                    bcnt_q <= '0;
                    way_q  <= hit_way;
                    if (hit && st_q[idx][hit_way] == LS_MOD) begin
                        snoop_retry <= 1'b1;
                        snp_q       <= 1'b1;
                        ctl_q       <= C_CAST;
                    end else begin
                        if (hit) st_q[idx][hit_way] <= LS_INV;
                        snoop_ack <= 1'b1;
                        ctl_q     <= C_IDLE;
                    end
                end
                C_CAST: begin
                    if (mem_ack) bcnt_q <= bcnt_q + 1'b1;
                    if (last_beat) begin
                        st_q[idx][way_q] <= LS_INV;
                        if (snp_q) begin
                            snoop_retry <= 1'b0;
                            snoop_ack   <= 1'b1;
                            ctl_q       <= C_IDLE;
                        end else begin
                            ctl_q <= C_LOOK;
                        end
                    end
                end
                C_FILL: begin
                    if (mem_ack) begin
                        bcnt_q <= bcnt_q + 1'b1;
                        fill_q <= fill_next;
                    end
                    if (last_beat) begin
                        st_q[idx][way_q] <= LS_EXCL;
                        ctl_q            <= C_LOOK;
                    end
                end
                default: ctl_q <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dc_checker.sv
// Protocol properties of the snooping cache, attached to the top by bind.
// Assumes the synchronous active-low reset is held for at least one edge.
module dc_checker #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              snoop_valid,
    input logic              snoop_retry,
    input logic              snoop_ack,
    input logic [WAYS-1:0]   hit_vec
);
    // R2: completion is a single-cycle pulse.
    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R2: completion never overlaps a burst.
    p_ready_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R3: the burst start address holds for the whole burst.
    p_burst_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    // R7: a burst never changes direction midway.
    p_burst_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_we));

    // R6: a tag is resident in at most one way of a set.
    p_single_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9: retry is only raised for a pending snoop.
    p_retry_for_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_retry |-> snoop_valid);

    // R9: retry drops together with the snoop completion.
    p_retry_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(snoop_retry) |-> snoop_ack);

    // R10: snoop completion is a single-cycle pulse.
    p_snoop_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_ack |=> !snoop_ack);
endmodule

bind snoop_mei_dcache dc_checker #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_ready   (cpu_ready),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .snoop_valid (snoop_valid),
    .snoop_retry (snoop_retry),
    .snoop_ack   (snoop_ack),
    .hit_vec     (hit_vec)
);

// File: tb/snoop_mei_dcache_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module snoop_mei_dcache_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [31:2] cpu_addr;
    logic [31:0] cpu_wdata, cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic        snoop_valid, snoop_retry, snoop_ack;
    logic [31:5] snoop_addr;

    int checks = 0;
    int failures = 0;
    int rd_beats = 0;
    int wr_beats = 0;
    logic [31:0] first_rd, first_wr;
    logic [31:0] wmem [logic [31:0]];

    always #2 clk = ~clk;

    snoop_mei_dcache uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .snoop_retry(snoop_retry), .snoop_ack(snoop_ack)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h3C3C, a[31:16]};
    endfunction

    function automatic logic [31:0] rdw(input logic [31:0] a);
        return wmem.exists(a) ? wmem[a] : pat(a);
    endfunction

    function automatic logic [31:0] mk(input int t, input int s, input int w);
        return {t[19:0], s[6:0], w[2:0], 2'b00};
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic clr_bus();
        rd_beats = 0;
        wr_beats = 0;
        first_rd = '1;
        first_wr = '1;
    endtask

    // Memory model: one beat per cycle, wrapping from the start beat.
    initial begin
        int beat;
        logic [1:0] pos;
        logic [31:0] ba;
        beat = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (!mem_req) begin
                mem_ack = 1'b0;
                beat = 0;
            end else if (beat < 4) begin
                pos = mem_addr[4:3] + 2'(beat);
                ba = {mem_addr[31:5], pos, 3'b000};
                if (beat == 0) begin
                    if (mem_we) first_wr = mem_addr;
                    else        first_rd = mem_addr;
                end
                if (mem_we) begin
                    wmem[ba]     = mem_wdata[31:0];
                    wmem[ba + 4] = mem_wdata[63:32];
                    wr_beats++;
                end else begin
                    mem_rdata = {rdw(ba + 4), rdw(ba)};
                    rd_beats++;
                end
                mem_ack = 1'b1;
                beat++;
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] q, output int cyc);
        cpu_we = we;
        cpu_addr = a[31:2];
        cpu_wdata = d;
        cpu_req = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 400);
        q = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic snoop_op(input logic [31:0] a, output logic retry, output int cyc);
        snoop_addr = a[31:5];
        snoop_valid = 1'b1;
        retry = 1'b0;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (snoop_retry) retry = 1'b1;
        end while (!snoop_ack && cyc < 400);
        snoop_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cpu_ready after reset", 32'(cpu_ready), 0);
        chk("R1 mem_req after reset", 32'(mem_req), 0);
        chk("R1 snoop_retry after reset", 32'(snoop_retry), 0);
        chk("R1 snoop_ack after reset", 32'(snoop_ack), 0);
    endtask

    task automatic t_read_miss();
        logic [31:0] q; int c;
        clr_bus();
        cpu_op(1'b0, mk(1, 3, 5), 0, q, c);
        chk("R1 R3 first access misses: latency", c, 7);
        chk("R3 critical word data", q, pat(mk(1, 3, 5)));
        chk("R3 fill beats", rd_beats, 4);
        chk("R3 fill start beat address", first_rd, {mk(1, 3, 0)} | 32'h10);
        chk("R3 no cast-out", wr_beats, 0);
    endtask

    task automatic t_read_hit();
        logic [31:0] q; int c;
        clr_bus();
        cpu_op(1'b0, mk(1, 3, 2), 0, q, c);
        chk("R2 hit latency", c, 2);
        chk("R2 hit data word 2", q, pat(mk(1, 3, 2)));
        chk("R2 no bus beats on hit", rd_beats + wr_beats, 0);
    endtask

    task automatic t_store_hit();
        logic [31:0] q; int c;
        clr_bus();
        cpu_op(1'b1, mk(1, 3, 2), 32'hDEAD_0002, q, c);
        chk("R4 store hit latency", c, 2);
        chk("R4 no write-through", wr_beats + rd_beats, 0);
        cpu_op(1'b0, mk(1, 3, 2), 0, q, c);
        chk("R4 stored word read back", q, 32'hDEAD_0002);
        cpu_op(1'b0, mk(1, 3, 3), 0, q, c);
        chk("R4 neighbour word untouched", q, pat(mk(1, 3, 3)));
    endtask

    task automatic t_snoop_mod();
        logic r; logic [31:0] q; int c;
        clr_bus();
        snoop_op(mk(1, 3, 0), r, c);
        chk("R9 retry raised on modified hit", 32'(r), 1);
        chk("R9 snoop push latency", c, 6);
        chk("R9 push beats", wr_beats, 4);
        chk("R9 push address", first_wr, mk(1, 3, 0));
        chk("R9 R4 pushed data", rdw(mk(1, 3, 2)), 32'hDEAD_0002);
        chk("R9 retry low after ack", 32'(snoop_retry), 0);
        cpu_op(1'b0, mk(1, 3, 2), 0, q, c);
        chk("R9 line invalid after push", c, 7);
        chk("R9 refetched data", q, 32'hDEAD_0002);
    endtask

    task automatic t_snoop_excl();
        logic r; logic [31:0] q; int c;
        cpu_op(1'b0, mk(2, 5, 0), 0, q, c);
        clr_bus();
        snoop_op(mk(2, 5, 0), r, c);
        chk("R8 no retry on exclusive hit", 32'(r), 0);
        chk("R8 snoop latency", c, 2);
        chk("R8 no bus beats", rd_beats + wr_beats, 0);
        cpu_op(1'b0, mk(2, 5, 0), 0, q, c);
        chk("R8 line invalidated", c, 7);
    endtask

    task automatic t_snoop_miss();
        logic r; logic [31:0] q; int c;
        clr_bus();
        snoop_op(mk(77, 5, 0), r, c);
        chk("R10 snoop miss latency", c, 2);
        chk("R10 no retry", 32'(r), 0);
        chk("R10 no bus beats", rd_beats + wr_beats, 0);
        cpu_op(1'b0, mk(2, 5, 0), 0, q, c);
        chk("R10 resident line still hits", c, 2);
    endtask

    task automatic t_priority();
        int c, cs, cc;
        cs = 0; cc = 0;
        snoop_addr = mk(88, 5, 0) >> 5;
        snoop_valid = 1'b1;
        cpu_we = 1'b0;
        cpu_addr = mk(2, 5, 1) >> 2;
        cpu_req = 1'b1;
        for (c = 1; c < 50 && cc == 0; c++) begin
            @(negedge clk);
            if (snoop_ack) begin cs = c; snoop_valid = 1'b0; end
            if (cpu_ready) begin cc = c; cpu_req = 1'b0; end
        end
        chk("R11 snoop served first", cs, 2);
        chk("R11 cpu served after snoop", cc, 4);
    endtask

    task automatic t_write_miss();
        logic r; logic [31:0] q; int c;
        clr_bus();
        cpu_op(1'b1, mk(3, 9, 7), 32'hBEEF_0007, q, c);
        chk("R5 write miss latency", c, 7);
        chk("R5 fill beats", rd_beats, 4);
        cpu_op(1'b0, mk(3, 9, 7), 0, q, c);
        chk("R5 merged store visible", q, 32'hBEEF_0007);
        cpu_op(1'b0, mk(3, 9, 6), 0, q, c);
        chk("R5 rest of line from memory", q, pat(mk(3, 9, 6)));
        snoop_op(mk(3, 9, 0), r, c);
        chk("R5 line modified after merge", 32'(r), 1);
    endtask

    task automatic t_lru();
        logic [31:0] q; int c;
        for (int t = 10; t < 14; t++) begin
            clr_bus();
            cpu_op(1'b0, mk(t, 12, 0), 0, q, c);
            chk("R6 invalid ways filled first", c + wr_beats, 7);
        end
        for (int t = 10; t < 14; t++) begin
            cpu_op(1'b0, mk(t, 12, 1), 0, q, c);
            chk("R6 all four ways resident", c, 2);
        end
        cpu_op(1'b0, mk(10, 12, 2), 0, q, c);
        cpu_op(1'b0, mk(14, 12, 0), 0, q, c);
        chk("R6 fifth tag misses", c, 7);
        cpu_op(1'b0, mk(11, 12, 0), 0, q, c);
        chk("R6 least recent way evicted", c, 7);
        cpu_op(1'b0, mk(10, 12, 0), 0, q, c);
        chk("R6 recently used way kept", c, 2);
    endtask

    task automatic t_dirty_victim();
        logic [31:0] q; int c;
        for (int t = 30; t < 34; t++) cpu_op(1'b1, mk(t, 20, 1), 32'hC0DE_0000 + t, q, c);
        clr_bus();
        cpu_op(1'b0, mk(34, 20, 0), 0, q, c);
        chk("R7 dirty victim latency", c, 12);
        chk("R7 cast-out beats", wr_beats, 4);
        chk("R7 cast-out address", first_wr, mk(30, 20, 0));
        chk("R7 cast-out data", rdw(mk(30, 20, 1)), 32'hC0DE_001E);
        chk("R7 fill after cast-out", rd_beats, 4);
        chk("R7 loaded word", q, pat(mk(34, 20, 0)));
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R1..R11 run actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        snoop_valid = 1'b0; snoop_addr = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss();
        t_read_hit();
        t_store_hit();
        t_snoop_mod();
        t_snoop_excl();
        t_snoop_miss();
        t_priority();
        t_write_miss();
        t_lru();
        t_dirty_victim();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule